// File: doc/BRIEF.md
# Wide-Bank Pattern and Nametable Mapper

This block sits between the picture processor's address bus and the cartridge graphics memories. Each picture address is steered to one of two places. The first is a byte address in the character ROM. The second is the console's internal nametable RAM, which is selected together with the value for that RAM's A10 line. The processor side programs the mapping through a write-only register port.

Every bank number is 16 bits wide and is assembled from a low-byte register and a high-byte register. There are eight pattern bank numbers and four nametable bank numbers. A size mode chooses how finely the 8 KiB pattern window is cut into banks.

The nametable window works in one of two ways:
- **From ROM.** Each 1 KiB nametable reads from a ROM bank. This mode is armed by a control write. It cancels itself whenever any nametable slot still holds its identity value.
- **From internal RAM.** A two-bit mirroring type picks vertical, horizontal or single-screen mirroring.

The address outputs are purely combinational. The write port has no back-pressure: a write is taken on every clock edge where `wr_valid` is high, and it always completes in that cycle.

Top module: `wbk_chr_mapper`

## Requirements
- R1: A write with wr_addr[15:12]=0x9 loads the low byte of pattern bank wr_addr[2:0]. A write with wr_addr[15:12]=0xA loads that bank's high byte. The bank number is high*256+low. Bits 11:3 of the address are not decoded.
- R2: A write with wr_addr[15:12]=0xD and wr_addr[2:0]=0 stores the pattern size mode from wr_data[4:3]. For ppu_addr[13]=0, chr_addr is formed as follows, where bank(k) is pattern bank k:
  - mode 0: bank(0)*8192+ppu_addr[12:0]
  - mode 1: bank(ppu_addr[12]?4:0)*4096+ppu_addr[11:0]
  - mode 2: bank(2*ppu_addr[12:11])*2048+ppu_addr[10:0]
  - mode 3: bank(ppu_addr[12:10])*1024+ppu_addr[9:0]
- R3: A write with wr_addr[15:12]=0xB loads a byte of nametable slot wr_addr[1:0]. It loads the low byte when wr_addr[2]=0 and the high byte when wr_addr[2]=1.
- R4: On a 0xD control write (wr_addr[2:0]=0), the ROM-nametable flag takes wr_data[5]. After that write, and after every 0xB write, the flag is cleared if any slot i has a high byte of 0 and a low byte of i. Once cleared, the flag stays clear until the next control write.
- R5: While the ROM-nametable flag is set and ppu_addr[13]=1, the outputs are rom_sel=1, ciram_sel=0 and chr_addr=slot(ppu_addr[11:10])*1024+ppu_addr[9:0].
- R6: While the flag is clear and ppu_addr[13]=1, the outputs are ciram_sel=1, rom_sel=0 and chr_addr=0. The mirroring type comes from wr_data[1:0] of a write with wr_addr[15:12]=0xD and wr_addr[2:0]=1. ciram_a10 is ppu_addr[10] for type 0, ppu_addr[11] for type 1, and 0 for types 2 and 3.
- R7: When ppu_addr[13]=0, the outputs are rom_sel=1 and ciram_sel=0.
- R8: After reset, pattern low byte i equals i. All high bytes and all nametable bytes are 0. The mode is 0, the mirroring type is 0 and the flag is clear.
- R9: The following writes change no output: writes to pages 0x8 and 0xC, and writes to page 0xD with wr_addr[2:0] other than 0 or 1. A mirroring write does not alter the flag.
- R10: chr_addr, rom_sel, ciram_sel and ciram_a10 follow ppu_addr in the same cycle, with no clock edge needed. chr_addr is the low CHR_AW bits of the computed byte address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Register write strobe, always accepted |
| wr_addr | input | 16 | Register write address |
| wr_data | input | 8 | Register write data |
| ppu_addr | input | 14 | Picture address |
| chr_addr | output | CHR_AW | Character ROM byte address |
| rom_sel | output | 1 | Character ROM is the target |
| ciram_sel | output | 1 | Internal nametable RAM is the target |
| ciram_a10 | output | 1 | A10 for the internal nametable RAM |

## Verification
The assertions check the following on every cycle:
- the two select outputs are never both high or both low;
- pattern addresses always go to ROM;
- single-screen mirroring keeps A10 low;
- mode 0 passes the low 13 address bits through unchanged;
- a low-byte write lands in the addressed register;
- the ROM-nametable flag is never set while an identity slot exists;
- non-control writes to page 0xD leave the mode and the flag alone.

Only the bench scenarios can show the remaining behaviour. This covers the full bank arithmetic of each size mode and the nametable selection under mixed write sequences. It also covers the self-cancelling flag staying clear until the next control write, which is observed at the address outputs.

// File: rtl/wbk_pkg.sv
package wbk_pkg;
  localparam int BYTE_W  = 8;
  localparam int BANK_W  = 2 * BYTE_W;
  localparam int NUM_PAT = 8;
  localparam int NUM_NT  = 4;
  localparam int PAT_IW  = $clog2(NUM_PAT);
  localparam int NT_IW   = $clog2(NUM_NT);

  typedef logic [BANK_W-1:0] bank_t;

  typedef enum logic [1:0] {
    PM_8K = 2'd0,
    PM_4K = 2'd1,
    PM_2K = 2'd2,
    PM_1K = 2'd3
  } pat_mode_e;

  localparam logic [3:0] PAGE_PLO = 4'h9;
  localparam logic [3:0] PAGE_PHI = 4'hA;
  localparam logic [3:0] PAGE_NT  = 4'hB;
  localparam logic [3:0] PAGE_CTL = 4'hD;
endpackage

// File: rtl/wbk_regfile.sv
module wbk_regfile
  import wbk_pkg::*;
(
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_valid,
  input  logic [15:0]            wr_addr,
  input  logic [BYTE_W-1:0]      wr_data,
  output bank_t [NUM_PAT-1:0]    pat_bank,
  output bank_t [NUM_NT-1:0]     nt_bank,
  output pat_mode_e              pat_mode,
  output logic [1:0]             mir_type,
  output logic                   rom_nt
);
  logic [NUM_PAT-1:0][BYTE_W-1:0] plo_q, phi_q;
  logic [NUM_NT-1:0][BYTE_W-1:0]  nlo_q, nhi_q, nlo_n, nhi_n;
  pat_mode_e                      mode_q;
  logic [1:0]                     mir_q;
  logic                           rom_q, rom_n;
  logic [NUM_NT-1:0]              ident_n, ident_q;
  logic [8:0]                     unused_addr_bits;

  assign unused_addr_bits = wr_addr[11:3];

  logic [3:0]        page;
  logic [PAT_IW-1:0] pidx;
  logic [NT_IW-1:0]  nidx;
  logic              nhigh;
  assign page  = wr_addr[15:12];
  assign pidx  = wr_addr[PAT_IW-1:0];
  assign nidx  = wr_addr[NT_IW-1:0];
  assign nhigh = wr_addr[NT_IW];

  logic hit_plo, hit_phi, hit_nt, hit_ctl, hit_mir;
  assign hit_plo = wr_valid && page == PAGE_PLO;
  assign hit_phi = wr_valid && page == PAGE_PHI;
  assign hit_nt  = wr_valid && page == PAGE_NT;
  assign hit_ctl = wr_valid && page == PAGE_CTL && wr_addr[2:0] == 3'd0;
  assign hit_mir = wr_valid && page == PAGE_CTL && wr_addr[2:0] == 3'd1;

  // nametable bytes as they will be after this cycle's write
  always_comb begin
    nlo_n = nlo_q;
    nhi_n = nhi_q;
    if (hit_nt) begin
      if (nhigh) nhi_n[nidx] = wr_data;
      else       nlo_n[nidx] = wr_data;
    end
  end

  for (genvar g = 0; g < NUM_NT; g++) begin : g_ident
    assign ident_n[g] = (nhi_n[g] == '0) && (nlo_n[g] == BYTE_W'(g));
    assign ident_q[g] = (nhi_q[g] == '0) && (nlo_q[g] == BYTE_W'(g));
  end

  always_comb begin
    rom_n = rom_q;
    if (hit_ctl)     rom_n = wr_data[5] & ~(|ident_n);
    else if (hit_nt) rom_n = rom_q & ~(|ident_n);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NUM_PAT; i++) plo_q[i] <= BYTE_W'(i);
      phi_q  <= '0;
      nlo_q  <= '0;
      nhi_q  <= '0;
      mode_q <= PM_8K;
      mir_q  <= 2'd0;
      rom_q  <= 1'b0;
    end else begin
      if (hit_plo) plo_q[pidx] <= wr_data;
      if (hit_phi) phi_q[pidx] <= wr_data;
      nlo_q <= nlo_n;
      nhi_q <= nhi_n;
      if (hit_ctl) mode_q <= pat_mode_e'(wr_data[4:3]);
      if (hit_mir) mir_q  <= wr_data[1:0];
      rom_q <= rom_n;
    end
  end

  for (genvar g = 0; g < NUM_PAT; g++) begin : g_pat
    assign pat_bank[g] = {phi_q[g], plo_q[g]};
  end
  for (genvar g = 0; g < NUM_NT; g++) begin : g_nt
    assign nt_bank[g] = {nhi_q[g], nlo_q[g]};
  end
  assign pat_mode = mode_q;
  assign mir_type = mir_q;
  assign rom_nt   = rom_q;

  // R1
  pat_lo_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    hit_plo |=> plo_q[$past(pidx)] == $past(wr_data));

  // R4
  rom_no_identity_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_q |-> !(|ident_q));

  // R9
  ctl_other_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_valid && page == PAGE_CTL && wr_addr[2:0] != 3'd0) |=>
      ($stable(rom_q) && $stable(mode_q)));
endmodule

// File: rtl/wbk_pattern_map.sv
module wbk_pattern_map
  import wbk_pkg::*;
#(
  parameter int CHR_AW = 20
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  bank_t [NUM_PAT-1:0]  pat_bank,
  input  pat_mode_e            pat_mode,
  input  logic [12:0]          ppu_off,
  output logic [CHR_AW-1:0]    pat_addr
);
  localparam int FW = BANK_W + 13;

  always_comb begin
    unique case (pat_mode)
      PM_8K: pat_addr = CHR_AW'((FW'(pat_bank[0]) << 13) | FW'(ppu_off[12:0]));
      PM_4K: pat_addr = CHR_AW'((FW'(pat_bank[{ppu_off[12], 2'b00}]) << 12)
                                | FW'(ppu_off[11:0]));
      PM_2K: pat_addr = CHR_AW'((FW'(pat_bank[{ppu_off[12:11], 1'b0}]) << 11)
                                | FW'(ppu_off[10:0]));
      default: pat_addr = CHR_AW'((FW'(pat_bank[ppu_off[12:10]]) << 10)
                                  | FW'(ppu_off[9:0]));
    endcase
  end

  // R2
  mode0_offset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (pat_mode == PM_8K) |-> (pat_addr[12:0] == ppu_off));
endmodule

// File: rtl/wbk_name_map.sv
module wbk_name_map
  import wbk_pkg::*;
#(
  parameter int CHR_AW = 20
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                rom_nt,
  input  logic [1:0]          mir_type,
  input  bank_t [NUM_NT-1:0]  nt_bank,
  input  logic                nt_region,
  input  logic [11:0]         nt_offset,
  input  logic [CHR_AW-1:0]   pat_addr,
  output logic [CHR_AW-1:0]   chr_addr,
  output logic                rom_sel,
  output logic                ciram_sel,
  output logic                ciram_a10
);
  localparam int FW = BANK_W + 10;

  always_comb begin
    chr_addr  = '0;
    rom_sel   = 1'b0;
    ciram_sel = 1'b0;
    ciram_a10 = 1'b0;
    if (!nt_region) begin
      rom_sel  = 1'b1;
      chr_addr = pat_addr;
    end else if (rom_nt) begin
      rom_sel  = 1'b1;
      chr_addr = CHR_AW'((FW'(nt_bank[nt_offset[11:10]]) << 10) | FW'(nt_offset[9:0]));
    end else begin
      ciram_sel = 1'b1;
      unique case (mir_type)
        2'd0:    ciram_a10 = nt_offset[10];
        2'd1:    ciram_a10 = nt_offset[11];
        default: ciram_a10 = 1'b0;
      endcase
    end
  end

  // R7
  pattern_to_rom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !nt_region |-> (rom_sel && !ciram_sel && chr_addr == pat_addr));

  // R6
  sel_exclusive_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rom_sel != ciram_sel);

  // R6
  single_screen_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (nt_region && !rom_nt && mir_type[1]) |-> !ciram_a10);
endmodule

// File: rtl/wbk_chr_mapper.sv
module wbk_chr_mapper
  import wbk_pkg::*;
#(
  parameter int CHR_AW = 20
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_valid,
  input  logic [15:0]        wr_addr,
  input  logic [7:0]         wr_data,
  input  logic [13:0]        ppu_addr,
  output logic [CHR_AW-1:0]  chr_addr,
  output logic               rom_sel,
  output logic               ciram_sel,
  output logic               ciram_a10
);
  bank_t [NUM_PAT-1:0] pat_bank;
  bank_t [NUM_NT-1:0]  nt_bank;
  pat_mode_e           pat_mode;
  logic [1:0]          mir_type;
  logic                rom_nt;
  logic [CHR_AW-1:0]   pat_addr;

  wbk_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .pat_bank (pat_bank),
    .nt_bank  (nt_bank),
    .pat_mode (pat_mode),
    .mir_type (mir_type),
    .rom_nt   (rom_nt)
  );

  wbk_pattern_map #(.CHR_AW(CHR_AW)) u_pat (
    .clk      (clk),
    .rst_n    (rst_n),
    .pat_bank (pat_bank),
    .pat_mode (pat_mode),
    .ppu_off  (ppu_addr[12:0]),
    .pat_addr (pat_addr)
  );

  wbk_name_map #(.CHR_AW(CHR_AW)) u_nt (
    .clk       (clk),
    .rst_n     (rst_n),
    .rom_nt    (rom_nt),
    .mir_type  (mir_type),
    .nt_bank   (nt_bank),
    .nt_region (ppu_addr[13]),
    .nt_offset (ppu_addr[11:0]),
    .pat_addr  (pat_addr),
    .chr_addr  (chr_addr),
    .rom_sel   (rom_sel),
    .ciram_sel (ciram_sel),
    .ciram_a10 (ciram_a10)
  );
endmodule

// File: tb/tb_wbk_chr_mapper.sv
`timescale 1ns/1ps
module tb_wbk_chr_mapper;
  localparam int CHR_AW = 20;
  localparam int OW = CHR_AW + 3;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_valid = 1'b0;
  logic [15:0] wr_addr = '0;
  logic [7:0] wr_data = '0;
  logic [13:0] ppu_addr = '0;
  logic [CHR_AW-1:0] chr_addr;
  logic rom_sel, ciram_sel, ciram_a10;

  always #10 clk = ~clk;

  wbk_chr_mapper #(.CHR_AW(CHR_AW)) dut (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
    .wr_data(wr_data), .ppu_addr(ppu_addr), .chr_addr(chr_addr),
    .rom_sel(rom_sel), .ciram_sel(ciram_sel), .ciram_a10(ciram_a10)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done = 1'b0;

  logic [7:0] m_plo [8];
  logic [7:0] m_phi [8];
  logic [7:0] m_nlo [4];
  logic [7:0] m_nhi [4];
  logic [1:0] m_mode, m_mir;
  logic       m_rom;

  function automatic bit ident_any();
    for (int i = 0; i < 4; i++)
      if (m_nhi[i] == 8'd0 && m_nlo[i] == 8'(i)) return 1'b1;
    return 1'b0;
  endfunction

  function automatic int pbank(input int k);
    return {m_phi[k], m_plo[k]};
  endfunction

  function automatic logic [OW-1:0] model_out(input logic [13:0] a);
    int full;
    logic r, c, t;
    r = 0; c = 0; t = 0; full = 0;
    if (!a[13]) begin
      r = 1;
      case (m_mode)
        2'd0: full = pbank(0) * 8192 + int'(a[12:0]);
        2'd1: full = pbank(a[12] ? 4 : 0) * 4096 + int'(a[11:0]);
        2'd2: full = pbank(int'(a[12:11]) * 2) * 2048 + int'(a[10:0]);
        default: full = pbank(int'(a[12:10])) * 1024 + int'(a[9:0]);
      endcase
    end else if (m_rom) begin
      r = 1;
      full = int'({m_nhi[a[11:10]], m_nlo[a[11:10]]}) * 1024 + int'(a[9:0]);
    end else begin
      c = 1;
      t = (m_mir == 2'd0) ? a[10] : (m_mir == 2'd1) ? a[11] : 1'b0;
    end
    return {r, c, t, full[CHR_AW-1:0]};
  endfunction

  task automatic model_reset();
    for (int i = 0; i < 8; i++) begin m_plo[i] = 8'(i); m_phi[i] = 0; end
    for (int i = 0; i < 4; i++) begin m_nlo[i] = 0; m_nhi[i] = 0; end
    m_mode = 0; m_mir = 0; m_rom = 0;
  endtask

  task automatic model_write(input logic [15:0] a, input logic [7:0] d);
    case (a[15:12])
      4'h9: m_plo[a[2:0]] = d;
      4'hA: m_phi[a[2:0]] = d;
      4'hB: begin
        if (a[2]) m_nhi[a[1:0]] = d; else m_nlo[a[1:0]] = d;
        if (ident_any()) m_rom = 0;
      end
      4'hD: begin
        if (a[2:0] == 3'd0) begin
          m_mode = d[4:3]; m_rom = d[5];
          if (ident_any()) m_rom = 0;
        end else if (a[2:0] == 3'd1) m_mir = d[1:0];
      end
      default: ;
    endcase
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_valid = 1'b0;
    model_write(a, d);
  endtask

  task automatic probe(input logic [13:0] a, input string tag);
    logic [OW-1:0] exp_v, act_v;
    @(negedge clk);
    ppu_addr = a;
    #2;
    exp_v = model_out(a);
    act_v = {rom_sel, ciram_sel, ciram_a10, chr_addr};
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL %s ppu=%h actual=%h expected=%h", tag, a, act_v, exp_v);
    end
  endtask

  // R10: two addresses back to back without any clock edge between them
  task automatic probe_pair(input logic [13:0] a, input logic [13:0] b);
    logic [OW-1:0] exp_v, act_v;
    @(negedge clk);
    ppu_addr = a; #1;
    ppu_addr = b; #1;
    exp_v = model_out(b);
    act_v = {rom_sel, ciram_sel, ciram_a10, chr_addr};
    n_chk++;
    if (act_v !== exp_v) begin
      n_bad++;
      $display("FAIL R10 ppu=%h actual=%h expected=%h", b, act_v, exp_v);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    int seed_dummy;
    seed_dummy = $urandom(32'h5EED_0043);
    model_reset();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R8 R7 reset state
    probe(14'h0000, "R8 reset pattern base");
    probe(14'h1ABC, "R8 R7 reset identity banks");
    probe(14'h2400, "R8 R6 reset vertical mirroring");

    // R4 slot 0 still identity at reset: request is cancelled
    wr(16'hD000, 8'h20);
    probe(14'h2000, "R4 cancelled at reset identity");

    // R3 R5 load non-identity slots then arm
    for (int i = 0; i < 4; i++) wr(16'hB000 | 16'(i), 8'h10 + 8'(i));
    wr(16'hB006, 8'h02);
    wr(16'hD000, 8'h20);
    probe(14'h2C05, "R5 slot3 from rom");
    probe(14'h2BFF, "R3 R5 slot2 high byte");
    probe_pair(14'h0123, 14'h2403);

    // R4 identity write cancels, stays cleared
    wr(16'hB001, 8'h01);
    probe(14'h2400, "R4 cancel on identity");
    wr(16'hB001, 8'h55);
    probe(14'h2400, "R4 stays cleared");
    wr(16'hD001, 8'h01);
    probe(14'h2800, "R6 R9 mirror write keeps flag clear");
    wr(16'hD000, 8'h20);
    probe(14'h2400, "R4 rearmed by control write");

    // R9 ignored writes
    wr(16'h8000, 8'hFF);
    wr(16'hC005, 8'hFF);
    wr(16'hD003, 8'hFF);
    wr(16'hD007, 8'hFF);
    probe(14'h2400, "R9 ignored writes nametable");
    probe(14'h1FFF, "R9 ignored writes pattern");

    // R1 R2 directed modes with high bytes and undecoded bits
    wr(16'h9FF4, 8'h07);
    wr(16'hA004, 8'h01);
    for (int m = 0; m < 4; m++) begin
      wr(16'hD000, 8'(m << 3));
      probe(14'h1234, "R1 R2 mode sweep hi");
      probe(14'h0A77, "R1 R2 mode sweep lo");
    end

    // R6 mirror types
    wr(16'hD000, 8'h00);
    for (int t = 0; t < 4; t++) begin
      wr(16'hD001, 8'(t));
      probe(14'h2C00, "R6 mirror type");
      probe(14'h2400, "R6 mirror type");
    end

    // constrained random
    for (int it = 0; it < 3000; it++) begin
      if ($urandom_range(0, 9) < 6) begin
        logic [15:0] a;
        logic [3:0] pg;
        pg = 4'(8 + $urandom_range(0, 5));
        a = {pg, 12'($urandom)};
        if (pg == 4'hD && $urandom_range(0, 1) == 1) a[2:0] = 3'($urandom_range(0, 1));
        wr(a, 8'($urandom));
      end else begin
        probe(14'($urandom), "R1 R2 R3 R5 R6 random");
      end
    end

    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule